// File: doc/BRIEF.md
# Timer Output Compare Channel

One compare channel that sits beside a 16-bit up/down timer counter. It compares the live count with an active compare register on every timer tick. A real match sets a sticky compare flag and drives a waveform output bit. A 2-bit output-action code chooses whether that bit is left alone, toggled, cleared or set. The counter, the pin direction logic and the interrupt logic are outside the block. The block receives the count, the direction, the tick enable, the TOP and BOTTOM indications and the CPU write events as inputs.

The CPU loads the compare value through one write port. In the two PWM modes the write lands in a shadow buffer, and the buffer is copied into the active register at a fixed point of the count cycle. This keeps pulses symmetric and free of glitches. In the plain (non-PWM) mode the write reaches the active register at once. A CPU write to the counter arms a one-shot inhibit that swallows the compare match of the next tick. A force strobe, accepted only in plain mode, makes the output react as if a match had occurred, but it does not touch the flag.

Top module: `ocu_channel`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, cmp_active_o, cmp_buf_o, flag_o and wave_o are all zero.
- R2: The mode_i encoding is 00 plain (non-PWM), 01 fast PWM and 10 phase-correct PWM; 11 behaves as plain. In plain mode a cmp_wr_i pulse loads cmp_wdata_i into both the active and the buffer register, visible one cycle later.
- R3: In the PWM modes a cmp_wr_i pulse loads only the buffer. The active register takes the pre-edge buffer value only on a tick_i cycle with at_top_i high (fast PWM) or with at_bottom_i high (phase-correct). At no other time does hardware change the active register.
- R4: A match is a cycle where tick_i is high, cnt_wr_i is low, the block is not inhibited and count_i equals the active value. After a match, flag_o is high from the next cycle on.
- R5: A flag_clr_i pulse clears flag_o on the next cycle. When a match and a clear arrive in the same cycle, the flag stays set.
- R6: The com_i encoding is 00 no change, 01 toggle, 10 clear and 11 set. In plain mode a match applies this action to wave_o, visible one cycle later.
- R7: In fast PWM a match applies the com_i action. A tick at TOP with no match applies the opposite action: set for 10, clear for 11, nothing for 01 and 00.
- R8: In phase-correct PWM a match with count_down_i low applies the com_i action. A match with count_down_i high applies the opposite action, and 01 still toggles only when counting up.
- R9: In plain mode force_i applies the com_i action to wave_o on the next cycle whether or not tick_i is high, and it never sets flag_o. In the PWM modes force_i has no effect.
- R10: A cnt_wr_i pulse suppresses any match in the same cycle and at the next tick_i cycle, however many tickless cycles come between. No flag and no output action follow from it.
- R11: com_i acts without buffering: a match uses the com_i value of its own cycle.
- R12: wave_o keeps its value when mode_i changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer clock enable for this cycle |
| count_i | input | 16 | Live counter value |
| count_down_i | input | 1 | High while the counter counts down |
| at_top_i | input | 1 | Counter is at TOP |
| at_bottom_i | input | 1 | Counter is at BOTTOM |
| mode_i | input | 2 | Waveform mode (see R2) |
| com_i | input | 2 | Output action code (see R6) |
| force_i | input | 1 | Force output compare strobe |
| cnt_wr_i | input | 1 | CPU write to the counter occurred |
| cmp_wr_i | input | 1 | CPU write to the compare value |
| cmp_wdata_i | input | 16 | Compare write data |
| flag_clr_i | input | 1 | CPU write of one to the flag |
| cmp_active_o | output | 16 | Active compare value |
| cmp_buf_o | output | 16 | Buffered compare value |
| flag_o | output | 1 | Compare match flag |
| wave_o | output | 1 | Waveform output bit |

## Verification
The assertions assume that at_top_i and at_bottom_i are never high in the same cycle, and one of them checks that assumption at the inputs. The random stimulus draws at most one of the two indications per cycle. It picks the count equal to the active compare value often enough that matches, inhibited matches and update points overlap in every mode. Directed sequences cover the cases where an update point and a match fall in the same cycle, where a flag is set and cleared together, and where the timer is stopped between a counter write and the next tick.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_FAST  = 2'b01,
    MODE_PHASE = 2'b10,
    MODE_RSVD  = 2'b11
  } mode_e;

  localparam logic [1:0] COM_NONE = 2'b00;
  localparam logic [1:0] COM_TOG  = 2'b01;
  localparam logic [1:0] COM_CLR  = 2'b10;
  localparam logic [1:0] COM_SET  = 2'b11;

  // inv selects the opposite action; toggle has no opposite
  function automatic logic apply_com(logic [1:0] com, logic inv, logic cur);
    logic r;
    unique case (com)
      COM_NONE: r = cur;
      COM_TOG:  r = inv ? cur : ~cur;
      COM_CLR:  r = inv;
      default:  r = ~inv;
    endcase
    return r;
  endfunction

  function automatic logic is_pwm(mode_e m);
    return (m == MODE_FAST) || (m == MODE_PHASE);
  endfunction
endpackage

// File: rtl/ocu_cmp_reg.sv
module ocu_cmp_reg
  import ocu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             tick_i,
  input  logic             at_top_i,
  input  logic             at_bottom_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] active_o,
  output logic [CNT_W-1:0] buf_o
);
  logic [CNT_W-1:0] active_q, buf_q;
  logic             buffered, load;

  assign buffered = is_pwm(mode_i);

  always_comb begin
    unique case (mode_i)
      MODE_FAST:  load = tick_i & at_top_i;
      MODE_PHASE: load = tick_i & at_bottom_i;
      default:    load = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      buf_q    <= '0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && !buffered) active_q <= wdata_i;
      else if (load)         active_q <= buf_q;
    end
  end

  assign active_o = active_q;
  assign buf_o    = buf_q;

  // R3
  active_hw_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) && !$past(load) |-> $stable(active_q));

  // R3
  buf_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_i) |-> $stable(buf_q));
endmodule

// File: rtl/ocu_match.sv
module ocu_match #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cnt_wr_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic             hit_o
);
  logic blk_q, eq;

  assign eq    = (count_i == cmp_i);
  assign hit_o = tick_i & ~cnt_wr_i & ~blk_q & eq;

  // inhibit holds through tickless cycles, released by the next tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       blk_q <= 1'b0;
    else if (cnt_wr_i) blk_q <= 1'b1;
    else if (tick_i)   blk_q <= 1'b0;
  end

  // R10
  cnt_wr_blocks_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_wr_i |=> !hit_o);

  // R4
  hit_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> tick_i && (count_i == cmp_i));
endmodule

// File: rtl/ocu_wave.sv
module ocu_wave
  import ocu_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  mode_e      mode_i,
  input  logic [1:0] com_i,
  input  logic       tick_i,
  input  logic       at_top_i,
  input  logic       count_down_i,
  input  logic       hit_i,
  input  logic       force_i,
  input  logic       flag_clr_i,
  output logic       wave_o,
  output logic       flag_o
);
  logic wave_q, wave_d, flag_q;

  always_comb begin
    wave_d = wave_q;
    unique case (mode_i)
      MODE_FAST: begin
        if (hit_i)                   wave_d = apply_com(com_i, 1'b0, wave_q);
        else if (tick_i && at_top_i) wave_d = apply_com(com_i, 1'b1, wave_q);
      end
      MODE_PHASE: begin
        if (hit_i) wave_d = apply_com(com_i, count_down_i, wave_q);
      end
      default: begin
        if (hit_i || force_i) wave_d = apply_com(com_i, 1'b0, wave_q);
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wave_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      wave_q <= wave_d;
      if (hit_i)           flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign wave_o = wave_q;
  assign flag_o = flag_q;

  // R4
  flag_rise_from_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit_i));

  // R9
  force_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i && !hit_i && !flag_clr_i |=> flag_q == $past(flag_q));

  // R12
  wave_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hit_i) && !$past(force_i) && !$past(tick_i) |-> $stable(wave_q));

  // R5
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !hit_i |=> !flag_q);
endmodule

// File: rtl/ocu_channel.sv
module ocu_channel
  import ocu_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             count_down_i,
  input  logic             at_top_i,
  input  logic             at_bottom_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       com_i,
  input  logic             force_i,
  input  logic             cnt_wr_i,
  input  logic             cmp_wr_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cmp_active_o,
  output logic [CNT_W-1:0] cmp_buf_o,
  output logic             flag_o,
  output logic             wave_o
);
  mode_e            mode;
  logic [CNT_W-1:0] active;
  logic             hit;

  assign mode = mode_e'(mode_i);

  ocu_cmp_reg #(.CNT_W(CNT_W)) u_cmp (
    .clk_i, .rst_ni,
    .mode_i     (mode),
    .tick_i,
    .at_top_i,
    .at_bottom_i,
    .wr_i       (cmp_wr_i),
    .wdata_i    (cmp_wdata_i),
    .active_o   (active),
    .buf_o      (cmp_buf_o)
  );

  ocu_match #(.CNT_W(CNT_W)) u_match (
    .clk_i, .rst_ni,
    .tick_i,
    .cnt_wr_i,
    .count_i,
    .cmp_i      (active),
    .hit_o      (hit)
  );

  ocu_wave u_wave (
    .clk_i, .rst_ni,
    .mode_i     (mode),
    .com_i,
    .tick_i,
    .at_top_i,
    .count_down_i,
    .hit_i      (hit),
    .force_i,
    .flag_clr_i,
    .wave_o,
    .flag_o
  );

  assign cmp_active_o = active;

  // R3
  top_bottom_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(at_top_i && at_bottom_i));
endmodule

// File: tb/tb_ocu_channel.sv
module tb_ocu_channel;
  localparam int W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni;
  logic tick, cnt_dn, top, bot, force_s, cnt_wr, cmp_wr, clr;
  logic [1:0] mode, com;
  logic [W-1:0] count, wdata;
  logic [W-1:0] act_o, buf_o;
  logic flag_o, wave_o;

  ocu_channel #(.CNT_W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .count_i(count),
    .count_down_i(cnt_dn), .at_top_i(top), .at_bottom_i(bot),
    .mode_i(mode), .com_i(com), .force_i(force_s), .cnt_wr_i(cnt_wr),
    .cmp_wr_i(cmp_wr), .cmp_wdata_i(wdata), .flag_clr_i(clr),
    .cmp_active_o(act_o), .cmp_buf_o(buf_o), .flag_o(flag_o), .wave_o(wave_o)
  );

  int n_run = 0, n_fail = 0;
  logic [W-1:0] m_act, m_buf;
  logic m_flag, m_wave, m_blk;

  function automatic logic act_fn(logic [1:0] c, logic inv, logic cur);
    case (c)
      2'b00: return cur;
      2'b01: return inv ? cur : ~cur;
      2'b10: return inv;
      default: return ~inv;
    endcase
  endfunction

  function automatic logic pwm(logic [1:0] m);
    return m == 2'b01 || m == 2'b10;
  endfunction

  // reference model from the requirements, evaluated on the pre-edge inputs
  task automatic model_step();
    logic hit, nw;
    logic [W-1:0] na;
    hit = tick && !cnt_wr && !m_blk && (count == m_act);
    na = m_act;
    if (cmp_wr && !pwm(mode)) na = wdata;
    else if (tick && ((mode == 2'b01 && top) || (mode == 2'b10 && bot))) na = m_buf;
    nw = m_wave;
    if (mode == 2'b01) begin
      if (hit) nw = act_fn(com, 1'b0, m_wave);
      else if (tick && top) nw = act_fn(com, 1'b1, m_wave);
    end else if (mode == 2'b10) begin
      if (hit) nw = act_fn(com, cnt_dn, m_wave);
    end else if (hit || force_s) nw = act_fn(com, 1'b0, m_wave);
    if (cmp_wr) m_buf = wdata;
    m_act = na;
    m_wave = nw;
    if (hit) m_flag = 1'b1; else if (clr) m_flag = 1'b0;
    if (cnt_wr) m_blk = 1'b1; else if (tick) m_blk = 1'b0;
  endtask

  task automatic chk(string tag, string what, logic [W-1:0] a, logic [W-1:0] e);
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, a, e);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag == "" ? "R3" : tag, "active", act_o, m_act);
    chk(tag == "" ? "R2" : tag, "buffer", buf_o, m_buf);
    chk(tag == "" ? "R4" : tag, "flag", {15'd0, flag_o}, {15'd0, m_flag});
    chk(tag == "" ? "R6" : tag, "wave", {15'd0, wave_o}, {15'd0, m_wave});
  endtask

  task automatic idle();
    tick = 0; top = 0; bot = 0; force_s = 0; cnt_wr = 0; cmp_wr = 0; clr = 0;
  endtask

  task automatic step(string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check_all(tag);
    idle();
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 0; idle(); mode = 0; com = 0; cnt_dn = 0; count = 0; wdata = 0;
    m_act = 0; m_buf = 0; m_flag = 0; m_wave = 0; m_blk = 0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1;
    @(negedge clk);
    check_all("R1");

    // R2 plain write goes straight to active
    cmp_wr = 1; wdata = 16'd100; step("R2");
    // R3 fast PWM: buffered until TOP tick
    mode = 2'b01; cmp_wr = 1; wdata = 16'd200; step("R3");
    tick = 1; count = 16'd5; step("R3");
    tick = 1; top = 1; count = 16'd9; step("R3");
    // R3 phase-correct: loads at BOTTOM only
    mode = 2'b10; cmp_wr = 1; wdata = 16'd300; step("R3");
    tick = 1; top = 1; count = 16'd1; step("R3");
    tick = 1; bot = 1; count = 16'd0; step("R3");
    // R4 R6 plain toggle on match
    mode = 2'b00; com = 2'b01; tick = 1; count = 16'd300; step("R4");
    com = 2'b11; tick = 1; count = 16'd300; step("R6");
    // R5 clear, then clear with simultaneous match
    clr = 1; step("R5");
    clr = 1; tick = 1; count = 16'd300; step("R5");
    clr = 1; step("R5");
    // R10 counter write, timer stopped, then tick at match value
    com = 2'b01; cnt_wr = 1; step("R10");
    step("R10"); step("R10");
    tick = 1; count = 16'd300; step("R10");
    tick = 1; count = 16'd300; step("R10");
    // R10 write and match in same cycle
    clr = 1; step("R10");
    cnt_wr = 1; tick = 1; count = 16'd300; step("R10");
    // R9 force in plain mode without tick, no flag
    com = 2'b10; force_s = 1; step("R9");
    com = 2'b11; force_s = 1; step("R9");
    mode = 2'b01; com = 2'b10; force_s = 1; step("R9");
    // R7 fast PWM: match clears, TOP sets
    tick = 1; count = 16'd300; step("R7");
    tick = 1; top = 1; count = 16'hFFFF; step("R7");
    com = 2'b11; tick = 1; count = 16'd300; step("R7");
    // R8 phase-correct up/down
    mode = 2'b10; com = 2'b10; cnt_dn = 0; tick = 1; count = 16'd300; step("R8");
    cnt_dn = 1; tick = 1; count = 16'd300; step("R8");
    com = 2'b01; tick = 1; count = 16'd300; step("R8");
    // R11 com change acts immediately
    mode = 2'b00; com = 2'b10; tick = 1; count = 16'd300; step("R11");
    com = 2'b11; tick = 1; count = 16'd300; step("R11");
    // R12 mode changes keep wave
    mode = 2'b01; step("R12"); mode = 2'b10; step("R12"); mode = 2'b11; step("R12");

    for (int i = 0; i < 4000; i++) begin
      int r;
      mode = 2'($urandom_range(0, 3));
      com = 2'($urandom_range(0, 3));
      tick = ($urandom_range(0, 3) != 0);
      cnt_dn = 1'($urandom_range(0, 1));
      r = $urandom_range(0, 9);
      top = (r == 0); bot = (r == 1);
      force_s = ($urandom_range(0, 7) == 0);
      cnt_wr = ($urandom_range(0, 9) == 0);
      cmp_wr = ($urandom_range(0, 7) == 0);
      clr = ($urandom_range(0, 5) == 0);
      wdata = 16'($urandom_range(0, 15));
      count = ($urandom_range(0, 9) < 4) ? m_act : 16'($urandom_range(0, 15));
      step("");
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule